// File: doc/BRIEF.md
# Front-Side Bus Handoff and Cycle Router

This block sits between a CPU front-side bus and three downstream ports: system memory (DRAM), the graphics port (AGP) and the PCI bus. For each address strobe that the CPU issues while it owns the bus, the block decides where the cycle goes. It then emits a one-cycle select pulse to that port, together with the captured address. In the same cycle it pulses the CPU's next-address line, which lets the CPU pipeline its next cycle. The one exception is a single, non-burst memory read, which gets no next-address pulse.

The block also hands the bus over to a PCI master. The handoff follows a fixed sequence:
- A request on `pci_req_n` makes the block ask the CPU to hold.
- The block waits for the CPU's hold acknowledge.
- It waits until both posted write buffers are empty: the one from CPU to PCI and the one from CPU to memory.
- Only then does it drive the grant.

Withdrawing the request first removes the grant and then releases the hold. While the hold is raised, the block ignores CPU strobes.

Handoff states:
- `ST_IDLE`: the CPU owns the bus.
- `ST_HOLD`: hold is raised and the block waits for acknowledge.
- `ST_DRAIN`: acknowledge has been seen and the block waits for both buffers to be empty.
- `ST_GRANT`: the grant is driven.
- `ST_RELEASE`: the grant is off and hold is still on for one cycle.

Transitions:
- IDLE→HOLD when the request is low.
- HOLD→DRAIN when acknowledge is high.
- DRAIN→GRANT when acknowledge is high and both buffers are empty.
- HOLD, DRAIN or GRANT→RELEASE when the request is withdrawn.
- RELEASE→IDLE always.

Top module: `hbh_ctrl`

## Requirements
- R1: During reset and in the first cycle after it, `cpu_hold` is 0, `pci_gnt_n` is 1, and all select pulses and `cpu_na` are 0.
- R2: An accepted strobe with `cpu_kind[1]`=0 (a memory cycle; `cpu_kind` 0 = memory read, 1 = memory write) gives a one-cycle `dram_sel` in the next cycle, with `route_addr` equal to the strobed address. At most one select is high at any time.
- R3: An accepted strobe with `cpu_kind[1]`=1 (an I/O cycle; 2 = read, 3 = write) whose `cpu_addr[IO_W-1:0]` lies within `agp_io_base`..`agp_io_limit`, both bounds included, gives `agp_sel` in the next cycle.
- R4: An accepted I/O strobe whose address lies outside that window gives `pci_sel` in the next cycle.
- R5: `cpu_na` pulses in the cycle after every accepted strobe, except a memory read with `cpu_burst`=0, for which it stays 0.
- R6: When `pci_req_n` is sampled low while `cpu_hold` is low, `cpu_hold` is high in the next cycle.
- R7: `pci_gnt_n` never goes low in the cycle after `cpu_hlda` was sampled low.
- R8: `pci_gnt_n` goes low only in the cycle after `pwb_empty` was sampled high in the drain state.
- R9: `pci_gnt_n` goes low only in the cycle after `mwb_empty` was sampled high in the drain state. A request that stays low while either buffer is busy stays pending, with no grant.
- R10: With the grant driven, sampling `pci_req_n` high raises `pci_gnt_n` in the next cycle while `cpu_hold` stays high. `cpu_hold` falls one cycle later.
- R11: A strobe sampled while `cpu_hold` is high is ignored: no select and no `cpu_na` follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_ads | input | 1 | CPU address strobe |
| cpu_addr | input | ADDR_W | CPU cycle address |
| cpu_kind | input | 2 | Cycle type: bit1 = I/O, bit0 = write |
| cpu_burst | input | 1 | Cycle is a burst |
| cpu_na | output | 1 | Next-address pulse to the CPU |
| cpu_hold | output | 1 | Hold request to the CPU |
| cpu_hlda | input | 1 | Hold acknowledge from the CPU |
| agp_io_base | input | IO_W | Lower bound of the AGP I/O window (inclusive) |
| agp_io_limit | input | IO_W | Upper bound of the AGP I/O window (inclusive) |
| dram_sel | output | 1 | Cycle routed to DRAM |
| agp_sel | output | 1 | Cycle routed to AGP |
| pci_sel | output | 1 | Cycle routed to PCI |
| route_addr | output | ADDR_W | Address of the routed cycle |
| pwb_empty | input | 1 | CPU-to-PCI posted write buffer is empty |
| mwb_empty | input | 1 | CPU-to-memory write buffer is empty |
| pci_req_n | input | 1 | PCI master request, active low |
| pci_gnt_n | output | 1 | PCI grant, active low |

## Verification
A wrong handoff state shows at `cpu_hold` or `pci_gnt_n` within one cycle of the sampled input that should have moved it. This is because both outputs are decoded directly from the state register. A grant that skips the drain appears one cycle after acknowledge, while a buffer still reports busy. A missed release leaves `cpu_hold` high a cycle too long. A routing fault shows in the pulse cycle that follows the strobe: a wrong select, a missing or extra `cpu_na`, or a strobe that leaks through while hold is raised.

// File: rtl/hbh_pkg.sv
package hbh_pkg;

    typedef enum logic [1:0] {
        CK_MEM_RD = 2'd0,
        CK_MEM_WR = 2'd1,
        CK_IO_RD  = 2'd2,
        CK_IO_WR  = 2'd3
    } cyc_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_HOLD    = 3'd1,
        ST_DRAIN   = 3'd2,
        ST_GRANT   = 3'd3,
        ST_RELEASE = 3'd4
    } hand_state_e;

endpackage

// File: rtl/hbh_route.sv
module hbh_route
    import hbh_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IO_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_ads,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [1:0]        cpu_kind,
    input  logic              cpu_burst,
    input  logic              hold_on,
    input  logic [IO_W-1:0]   win_lo,
    input  logic [IO_W-1:0]   win_hi,
    output logic              dram_sel,
    output logic              agp_sel,
    output logic              pci_sel,
    output logic              cpu_na,
    output logic [ADDR_W-1:0] route_addr
);

    logic            accept;
    logic            is_io;
    logic            single_rd;
    logic            in_window;
    logic [IO_W-1:0] io_port;

    always_comb begin
        io_port   = cpu_addr[IO_W-1:0];
        accept    = cpu_ads && !hold_on;
        is_io     = cpu_kind[1];
        single_rd = (cpu_kind == CK_MEM_RD) && !cpu_burst;
        in_window = (io_port >= win_lo) && (io_port <= win_hi);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dram_sel   <= 1'b0;
            agp_sel    <= 1'b0;
            pci_sel    <= 1'b0;
            cpu_na     <= 1'b0;
            route_addr <= '0;
        end else begin
            dram_sel <= accept && !is_io;
            agp_sel  <= accept && is_io && in_window;
            pci_sel  <= accept && is_io && !in_window;
            cpu_na   <= accept && !single_rd;
            if (accept) begin
                route_addr <= cpu_addr;
            end
        end
    end

    assert_one_target_R2 : assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dram_sel, agp_sel, pci_sel}));

    assert_no_na_single_read_R5 : assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ads && !hold_on && cpu_kind == CK_MEM_RD && !cpu_burst) |=> !cpu_na);

    assert_hold_blocks_cycles_R11 : assert property (@(posedge clk) disable iff (!rst_n)
        hold_on |=> !(dram_sel || agp_sel || pci_sel || cpu_na));

endmodule

// File: rtl/hbh_arb.sv
module hbh_arb
    import hbh_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pci_req_n,
    input  logic cpu_hlda,
    input  logic pwb_empty,
    input  logic mwb_empty,
    output logic cpu_hold,
    output logic pci_gnt_n
);

    hand_state_e state_q;
    hand_state_e state_d;
    logic        drained;

    always_comb begin
        drained = pwb_empty && mwb_empty;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!pci_req_n) state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (pci_req_n)     state_d = ST_RELEASE;
                else if (cpu_hlda) state_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (pci_req_n)                state_d = ST_RELEASE;
                else if (cpu_hlda && drained) state_d = ST_GRANT;
            end
            ST_GRANT: begin
                if (pci_req_n) state_d = ST_RELEASE;
            end
            ST_RELEASE: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        cpu_hold  = 1'b0;
        pci_gnt_n = 1'b1;
        unique case (state_q)
            ST_IDLE:    ;
            ST_HOLD:    cpu_hold = 1'b1;
            ST_DRAIN:   cpu_hold = 1'b1;
            ST_GRANT: begin
                cpu_hold  = 1'b1;
                pci_gnt_n = 1'b0;
            end
            ST_RELEASE: cpu_hold = 1'b1;
            default:    ;
        endcase
    end

    assert_req_raises_hold_R6 : assert property (@(posedge clk) disable iff (!rst_n)
        (!pci_req_n && !cpu_hold) |=> cpu_hold);

    assert_no_grant_without_ack_R7 : assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_hlda && pci_gnt_n) |=> pci_gnt_n);

    assert_grant_after_pwb_R8 : assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pci_gnt_n) |-> $past(pwb_empty));

    assert_grant_after_mwb_R9 : assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pci_gnt_n) |-> $past(mwb_empty));

    assert_release_order_R10 : assert property (@(posedge clk) disable iff (!rst_n)
        (!pci_gnt_n && pci_req_n) |=> (pci_gnt_n && cpu_hold));

endmodule

// File: rtl/hbh_ctrl.sv
module hbh_ctrl
    import hbh_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IO_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_ads,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [1:0]        cpu_kind,
    input  logic              cpu_burst,
    output logic              cpu_na,
    output logic              cpu_hold,
    input  logic              cpu_hlda,
    input  logic [IO_W-1:0]   agp_io_base,
    input  logic [IO_W-1:0]   agp_io_limit,
    output logic              dram_sel,
    output logic              agp_sel,
    output logic              pci_sel,
    output logic [ADDR_W-1:0] route_addr,
    input  logic              pwb_empty,
    input  logic              mwb_empty,
    input  logic              pci_req_n,
    output logic              pci_gnt_n
);

    logic hold_w;

    hbh_arb u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .pci_req_n (pci_req_n),
        .cpu_hlda  (cpu_hlda),
        .pwb_empty (pwb_empty),
        .mwb_empty (mwb_empty),
        .cpu_hold  (hold_w),
        .pci_gnt_n (pci_gnt_n)
    );

    hbh_route #(
        .ADDR_W (ADDR_W),
        .IO_W   (IO_W)
    ) u_route (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_ads    (cpu_ads),
        .cpu_addr   (cpu_addr),
        .cpu_kind   (cpu_kind),
        .cpu_burst  (cpu_burst),
        .hold_on    (hold_w),
        .win_lo     (agp_io_base),
        .win_hi     (agp_io_limit),
        .dram_sel   (dram_sel),
        .agp_sel    (agp_sel),
        .pci_sel    (pci_sel),
        .cpu_na     (cpu_na),
        .route_addr (route_addr)
    );

    assign cpu_hold = hold_w;

endmodule

// File: tb/hbh_ctrl_tb_top.sv
module hbh_ctrl_tb_top;

    localparam int AW = 32;
    localparam int IW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_ads = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [1:0]    cpu_kind = 2'd0;
    logic          cpu_burst = 1'b0;
    logic          cpu_hlda = 1'b0;
    logic [IW-1:0] agp_io_base = 16'h3000;
    logic [IW-1:0] agp_io_limit = 16'h30FF;
    logic          pwb_empty = 1'b1;
    logic          mwb_empty = 1'b1;
    logic          pci_req_n = 1'b1;
    logic          cpu_na, cpu_hold, dram_sel, agp_sel, pci_sel, pci_gnt_n;
    logic [AW-1:0] route_addr;

    int vectors = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    hbh_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_ads(cpu_ads), .cpu_addr(cpu_addr),
        .cpu_kind(cpu_kind), .cpu_burst(cpu_burst), .cpu_na(cpu_na),
        .cpu_hold(cpu_hold), .cpu_hlda(cpu_hlda), .agp_io_base(agp_io_base),
        .agp_io_limit(agp_io_limit), .dram_sel(dram_sel), .agp_sel(agp_sel),
        .pci_sel(pci_sel), .route_addr(route_addr), .pwb_empty(pwb_empty),
        .mwb_empty(mwb_empty), .pci_req_n(pci_req_n), .pci_gnt_n(pci_gnt_n)
    );

    // Reference model: phase 0 idle, 1 holding, 2 draining, 3 granted, 4 releasing
    int            m_phase = 0;
    bit            m_dram = 0, m_agp = 0, m_pci = 0, m_na = 0;
    logic [AW-1:0] m_addr = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase <= 0;
            m_dram <= 0; m_agp <= 0; m_pci <= 0; m_na <= 0;
            m_addr <= '0;
        end else begin
            automatic bit taken = cpu_ads && (m_phase == 0);
            automatic int port = cpu_addr[IW-1:0];
            automatic bit inwin = (port >= agp_io_base) && (port <= agp_io_limit);
            m_dram <= taken && (cpu_kind < 2);
            m_agp  <= taken && (cpu_kind >= 2) && inwin;
            m_pci  <= taken && (cpu_kind >= 2) && !inwin;
            m_na   <= taken && !(cpu_kind == 0 && !cpu_burst);
            if (taken) m_addr <= cpu_addr;
            if (m_phase == 0) begin
                if (!pci_req_n) m_phase <= 1;
            end else if (m_phase == 4) begin
                m_phase <= 0;
            end else if (pci_req_n) begin
                m_phase <= 4;
            end else if (m_phase == 1 && cpu_hlda) begin
                m_phase <= 2;
            end else if (m_phase == 2 && cpu_hlda && pwb_empty && mwb_empty) begin
                m_phase <= 3;
            end
        end
    end

    task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cycles, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        cycles++;
        chk("R6 R10 hold", AW'(cpu_hold), AW'(m_phase != 0));
        chk("R7 R8 R9 grant_n", AW'(pci_gnt_n), AW'(m_phase != 3));
        chk("R2 dram_sel", AW'(dram_sel), AW'(m_dram));
        chk("R3 agp_sel", AW'(agp_sel), AW'(m_agp));
        chk("R4 pci_sel", AW'(pci_sel), AW'(m_pci));
        chk("R5 R11 next_addr", AW'(cpu_na), AW'(m_na));
        if (m_dram || m_agp || m_pci) chk("R2 route_addr", route_addr, m_addr);
    endtask

    task automatic strobe(input logic [AW-1:0] a, input logic [1:0] k, input logic b);
        cpu_ads = 1'b1; cpu_addr = a; cpu_kind = k; cpu_burst = b;
        tick();
        cpu_ads = 1'b0;
        tick();
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            if (cycles > 100000) begin
                fails++;
                $display("FAIL watchdog: actual hung expected finish");
                summary();
            end
        end
    end

    initial begin
        tick(); tick();
        // R1 reset values
        chk("R1 reset hold", AW'(cpu_hold), 0);
        chk("R1 reset grant_n", AW'(pci_gnt_n), 1);
        chk("R1 reset selects", AW'({dram_sel, agp_sel, pci_sel, cpu_na}), 0);
        rst_n = 1'b1;
        tick();
        chk("R1 post reset selects", AW'({dram_sel, agp_sel, pci_sel, cpu_na}), 0);
        // R2 R5 memory cycles
        strobe(32'h0010_0000, 2'd0, 1'b0);
        strobe(32'h0010_0040, 2'd0, 1'b1);
        strobe(32'h0020_0008, 2'd1, 1'b0);
        // R3 R4 window edges
        strobe(32'h0000_3000, 2'd2, 1'b0);
        strobe(32'h0000_30FF, 2'd3, 1'b0);
        strobe(32'h0000_2FFF, 2'd2, 1'b0);
        strobe(32'h0000_3100, 2'd3, 1'b0);
        // R6..R9 handoff with busy buffers, R11 strobes ignored under hold
        pwb_empty = 1'b0; mwb_empty = 1'b0;
        pci_req_n = 1'b0;
        tick(); tick();
        strobe(32'h0030_0000, 2'd1, 1'b1);
        cpu_hlda = 1'b1;
        tick(); tick();
        pwb_empty = 1'b1;
        tick(); tick();
        chk("R9 pending without grant", AW'(pci_gnt_n), 1);
        mwb_empty = 1'b1;
        tick(); tick();
        chk("R8 R9 grant after drain", AW'(pci_gnt_n), 0);
        pci_req_n = 1'b1;
        tick();
        chk("R10 grant off hold on", AW'({pci_gnt_n, cpu_hold}), 3);
        tick();
        chk("R10 hold off", AW'(cpu_hold), 0);
        cpu_hlda = 1'b0;
        tick();
        // R7 no grant while ack low
        pci_req_n = 1'b0;
        repeat (4) tick();
        chk("R7 no grant without ack", AW'(pci_gnt_n), 1);
        pci_req_n = 1'b1;
        tick(); tick();
        // random traffic
        for (int i = 0; i < 3000; i++) begin
            cpu_ads   = $urandom_range(0, 1);
            cpu_addr  = {$urandom_range(0, 65535), 16'h3000 + 16'($urandom_range(0, 511)) - 16'h80};
            cpu_kind  = 2'($urandom_range(0, 3));
            cpu_burst = $urandom_range(0, 1);
            cpu_hlda  = (cpu_hold && $urandom_range(0, 3) != 0);
            pwb_empty = $urandom_range(0, 2) != 0;
            mwb_empty = $urandom_range(0, 2) != 0;
            if ($urandom_range(0, 9) == 0) pci_req_n = ~pci_req_n;
            tick();
        end
        done = 1'b1;
        summary();
    end

endmodule